// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block is the transmit DMA engine of an Ethernet MAC. Software builds a linked list of descriptors in memory. Each descriptor is three little-endian 32-bit words: the buffer address at offset 0, a size word at offset 4, and the address of the next descriptor at offset 8. In the size word, bit 31 is the empty flag and bits 10:0 hold the packet length in bytes.

Software loads the head pointer and then writes 1 to the DMA enable. If the MAC transmit enable is high at that moment, the walker starts following the chain. For each full descriptor it reads the buffer one word at a time over a request/grant memory port and streams the bytes out. It then writes the size word back with the empty flag set, pulses a packet-sent strobe and moves to the next descriptor. When it reaches a descriptor whose empty flag is already set, it pulses an underrun strobe, clears its own enable and stops.

The byte output is valid/ready. A byte moves on a clock edge where valid and ready are both high. While ready is low, valid, data and last hold still and the walker waits. When the loopback select is high, frames leave on the loopback stream toward the receive path and the line stream stays silent. The select must only change while the walker is idle.

Top module: `tx_desc_walker`

## Requirements
- R1: A write of 1 to the DMA enable starts a walk only if `mac_tx_en` is high in that cycle. Otherwise no memory request is issued, although `dma_en` still reads 1.
- R2: For each descriptor the walker first reads the size word at pointer+4. A non-empty descriptor then gets its buffer address read at pointer+0 and its next pointer read at pointer+8. Bit 31 of the size word is the empty flag and bits 10:0 are the length; bits 30:11 are ignored.
- R3: A descriptor with bit 31 set produces a one-cycle `underrun_stb`. After it, `dma_en` is 0, no byte is sent and no further request is made.
- R4: A descriptor of length L sends exactly L bytes. Each buffer word is sent least significant byte first, the last word is trimmed to the length, and `byte_last` is high only on byte L.
- R5: After the last byte of a descriptor is accepted, the walker writes the original size word with bit 31 set back to pointer+4. It then gives exactly one `pkt_sent_stb` pulse and follows the next pointer. The two strobes are never high together.
- R6: While a valid byte sees ready low, valid, data and last stay unchanged. No byte is lost or repeated.
- R7: With `loopback_sel` high, bytes leave only on the loopback stream (`lb_valid`). With it low, they leave only on the line stream. The two valids are never high together.
- R8: Address bits 1:0 are dropped from the head pointer, the buffer address and the next pointer. The head pointer register is not advanced by a walk, so a new start begins at the same head.
- R9: A zero-length descriptor sends no bytes but is still written back, strobed and followed.
- R10: A memory request holds its address, write flag and data until it is granted. Only one read is outstanding at a time, and its data is taken on `mem_rvalid`.
- R11: After reset, the walker is idle: `dma_en` is 0 and there is no request, no valid byte and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mac_tx_en | input | 1 | MAC transmit enable from the configuration register |
| loopback_sel | input | 1 | Route frames to the receive path instead of the line |
| dma_en_wr | input | 1 | Write strobe for the DMA enable bit |
| dma_en_wdata | input | 1 | Value written to the DMA enable bit |
| desc_ptr_wr | input | 1 | Write strobe for the head descriptor pointer |
| desc_ptr_wdata | input | 32 | Head descriptor pointer value; bits 1:0 are dropped |
| dma_en | output | 1 | Current DMA enable bit |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted on this edge |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| line_valid | output | 1 | Byte valid on the line stream |
| line_ready | input | 1 | Line stream ready |
| lb_valid | output | 1 | Byte valid on the loopback stream |
| lb_ready | input | 1 | Loopback stream ready |
| byte_data | output | 8 | Byte shared by both streams |
| byte_last | output | 1 | Final byte of the frame |
| pkt_sent_stb | output | 1 | One pulse per descriptor completed |
| underrun_stb | output | 1 | One pulse when an empty descriptor stops the walk |

## Verification
The walk is driven through chains of one to four descriptors with random lengths from 0 to 60. The lengths include non-multiples of four, which exercise word trimming, and zero, which shows that a descriptor is completed without data. Junk is placed in bits 30:11 of the size words and in the low bits of the pointers, which shows that only the length field and word addresses are used. The memory grant, the read latency and the stream ready are randomized, which separates correct stalling from dropped or repeated bytes. Directed runs cover a start with `mac_tx_en` low, a loopback walk, and a restart over an already-consumed chain, which must underrun at once at the same head.

// File: rtl/txw_pkg.sv
package txw_pkg;

  typedef enum logic [3:0] {
    W_IDLE,
    W_SZ_REQ,
    W_SZ_WAIT,
    W_BA_REQ,
    W_BA_WAIT,
    W_NX_REQ,
    W_NX_WAIT,
    W_BUF_REQ,
    W_BUF_WAIT,
    W_DRAIN,
    W_WB_REQ,
    W_SENT,
    W_STOP
  } walk_state_e;

endpackage

// File: rtl/txw_lane.sv
module txw_lane #(
  parameter int DW = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld,
  input  logic [DW-1:0]                ld_word,
  input  logic [$clog2(DW/8+1)-1:0]    ld_cnt,
  input  logic                         ld_last,
  output logic                         o_valid,
  input  logic                         o_ready,
  output logic [7:0]                   o_data,
  output logic                         o_last,
  output logic                         busy
);
  localparam int CNTW = $clog2(DW/8 + 1);

  logic [DW-1:0]   word_q;
  logic [CNTW-1:0] cnt_q;
  logic            last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (ld) begin
      word_q <= ld_word;
      cnt_q  <= ld_cnt;
      last_q <= ld_last;
    end else if (o_valid && o_ready) begin
      word_q <= word_q >> 8;
      cnt_q  <= cnt_q - CNTW'(1);
    end
  end

  assign o_valid = (cnt_q != '0);
  assign o_data  = word_q[7:0];
  assign o_last  = last_q && (cnt_q == CNTW'(1));
  assign busy    = o_valid;
endmodule

// File: rtl/txw_seq.sv
module txw_seq
  import txw_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LEN_W     = 11,
  parameter int EMPTY_BIT = 31
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mac_tx_en,
  input  logic                         en_wr,
  input  logic                         en_wdata,
  input  logic                         ptr_wr,
  input  logic [AW-1:0]                ptr_wdata,
  output logic                         dma_en,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [AW-1:0]                mem_addr,
  output logic [DW-1:0]                mem_wdata,
  input  logic                         mem_gnt,
  input  logic                         mem_rvalid,
  input  logic [DW-1:0]                mem_rdata,
  output logic                         ld,
  output logic [DW-1:0]                ld_word,
  output logic [$clog2(DW/8+1)-1:0]    ld_cnt,
  output logic                         ld_last,
  input  logic                         lane_busy,
  output logic                         pkt_sent_stb,
  output logic                         underrun_stb
);
  localparam int BPW  = DW / 8;
  localparam int CNTW = $clog2(BPW + 1);

  function automatic logic [AW-1:0] align(input logic [AW-1:0] a);
    return a & ~AW'(BPW - 1);
  endfunction

  walk_state_e      st;
  logic [AW-1:0]    head, cur, nxt, baddr;
  logic [DW-1:0]    szw;
  logic [LEN_W-1:0] rem;
  logic             en_q;
  logic [LEN_W-1:0] take;

  assign take = (rem >= LEN_W'(BPW)) ? LEN_W'(BPW) : rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= W_IDLE;
      head  <= '0;
      cur   <= '0;
      nxt   <= '0;
      baddr <= '0;
      szw   <= '0;
      rem   <= '0;
      en_q  <= 1'b0;
    end else begin
      if (ptr_wr) head <= align(ptr_wdata);
      if (en_wr)  en_q <= en_wdata;
      case (st)
        W_IDLE: if (en_wr && en_wdata && mac_tx_en) begin
          cur <= head;
          st  <= W_SZ_REQ;
        end
        W_SZ_REQ: if (mem_gnt) st <= W_SZ_WAIT;
        W_SZ_WAIT: if (mem_rvalid) begin
          szw <= mem_rdata;
          rem <= mem_rdata[LEN_W-1:0];
          st  <= mem_rdata[EMPTY_BIT] ? W_STOP : W_BA_REQ;
        end
        W_BA_REQ: if (mem_gnt) st <= W_BA_WAIT;
        W_BA_WAIT: if (mem_rvalid) begin
          baddr <= align(AW'(mem_rdata));
          st    <= W_NX_REQ;
        end
        W_NX_REQ: if (mem_gnt) st <= W_NX_WAIT;
        W_NX_WAIT: if (mem_rvalid) begin
          nxt <= align(AW'(mem_rdata));
          st  <= (rem == '0) ? W_WB_REQ : W_BUF_REQ;
        end
        W_BUF_REQ: if (mem_gnt) st <= W_BUF_WAIT;
        W_BUF_WAIT: if (mem_rvalid) begin
          rem   <= rem - take;
          baddr <= baddr + AW'(BPW);
          st    <= W_DRAIN;
        end
        W_DRAIN: if (!lane_busy) st <= (rem == '0) ? W_WB_REQ : W_BUF_REQ;
        W_WB_REQ: if (mem_gnt) st <= W_SENT;
        W_SENT: begin
          cur <= nxt;
          st  <= W_SZ_REQ;
        end
        W_STOP: begin
          en_q <= 1'b0;
          st   <= W_IDLE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = szw | (DW'(1) << EMPTY_BIT);
    case (st)
      W_SZ_REQ:  begin mem_req = 1'b1; mem_addr = cur + AW'(BPW);     end
      W_BA_REQ:  begin mem_req = 1'b1; mem_addr = cur;                end
      W_NX_REQ:  begin mem_req = 1'b1; mem_addr = cur + AW'(2 * BPW); end
      W_BUF_REQ: begin mem_req = 1'b1; mem_addr = baddr;              end
      W_WB_REQ:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur + AW'(BPW); end
      default: ;
    endcase
  end

  assign ld           = (st == W_BUF_WAIT) && mem_rvalid;
  assign ld_word      = mem_rdata;
  assign ld_cnt       = take[CNTW-1:0];
  assign ld_last      = (rem <= LEN_W'(BPW));
  assign pkt_sent_stb = (st == W_SENT);
  assign underrun_stb = (st == W_STOP);
  assign dma_en       = en_q;
endmodule

// File: rtl/tx_desc_walker.sv
module tx_desc_walker #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LEN_W     = 11,
  parameter int EMPTY_BIT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mac_tx_en,
  input  logic          loopback_sel,
  input  logic          dma_en_wr,
  input  logic          dma_en_wdata,
  input  logic          desc_ptr_wr,
  input  logic [AW-1:0] desc_ptr_wdata,
  output logic          dma_en,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          line_valid,
  input  logic          line_ready,
  output logic          lb_valid,
  input  logic          lb_ready,
  output logic [7:0]    byte_data,
  output logic          byte_last,
  output logic          pkt_sent_stb,
  output logic          underrun_stb
);
  localparam int CNTW = $clog2(DW/8 + 1);

  logic            ld, ld_last, lane_busy, s_valid, s_ready;
  logic [DW-1:0]   ld_word;
  logic [CNTW-1:0] ld_cnt;

  txw_seq #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .EMPTY_BIT(EMPTY_BIT)) seq_i (
    .clk(clk), .rst_n(rst_n), .mac_tx_en(mac_tx_en),
    .en_wr(dma_en_wr), .en_wdata(dma_en_wdata),
    .ptr_wr(desc_ptr_wr), .ptr_wdata(desc_ptr_wdata), .dma_en(dma_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ld(ld), .ld_word(ld_word), .ld_cnt(ld_cnt), .ld_last(ld_last),
    .lane_busy(lane_busy), .pkt_sent_stb(pkt_sent_stb), .underrun_stb(underrun_stb)
  );

  txw_lane #(.DW(DW)) lane_i (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_word(ld_word), .ld_cnt(ld_cnt),
    .ld_last(ld_last), .o_valid(s_valid), .o_ready(s_ready),
    .o_data(byte_data), .o_last(byte_last), .busy(lane_busy)
  );

  assign line_valid = s_valid && !loopback_sel;
  assign lb_valid   = s_valid &&  loopback_sel;
  assign s_ready    = loopback_sel ? lb_ready : line_ready;
endmodule

// File: rtl/txw_chk.sv
module txw_chk #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int EMPTY_BIT = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_gnt,
  input logic          line_valid,
  input logic          line_ready,
  input logic          lb_valid,
  input logic          lb_ready,
  input logic [7:0]    byte_data,
  input logic          byte_last,
  input logic          dma_en,
  input logic          pkt_sent_stb,
  input logic          underrun_stb
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_word_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  assert_wb_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[EMPTY_BIT]);

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pkt_sent_stb, underrun_stb}));

  assert_underrun_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_stb |=> !dma_en && !mem_req);

  assert_line_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid && !line_ready |=> line_valid && $stable(byte_data) && $stable(byte_last));

  assert_lb_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lb_valid && !lb_ready |=> lb_valid && $stable(byte_data) && $stable(byte_last));

  assert_one_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({line_valid, lb_valid}));
endmodule

bind tx_desc_walker txw_chk #(.AW(AW), .DW(DW), .EMPTY_BIT(EMPTY_BIT)) chk_i (.*);

// File: tb/tx_desc_walker_tb_top.sv
module tx_desc_walker_tb_top;
  localparam int MW = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        mac_tx_en, loopback_sel, dma_en_wr, dma_en_wdata, desc_ptr_wr;
  logic [31:0] desc_ptr_wdata;
  logic        dma_en, mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        line_valid, line_ready, lb_valid, lb_ready, byte_last;
  logic [7:0]  byte_data;
  logic        pkt_sent_stb, underrun_stb;

  tx_desc_walker dut_i (.*);

  logic [31:0] mem [MW];
  int          checks = 0, fails = 0;
  logic [7:0]  got_b[$];
  bit          got_l[$];
  int          got_line, got_lb, n_sent, n_under, n_req;
  logic [31:0] first_rd;
  bit          first_seen, rdy_full;
  bit          rd_pend = 0;
  int          rd_dly = 0;
  logic [31:0] rd_addr = '0;
  int          lens[8];
  logic [31:0] szo[8];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model and stream sink, driven away from the active edge
  initial begin
    mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0; line_ready = 0; lb_ready = 0;
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      mem_gnt    = 0;
      line_ready = rdy_full ? 1'b1 : ($urandom % 3 != 0);
      lb_ready   = rdy_full ? 1'b1 : ($urandom % 3 != 0);
      if (rd_pend) begin
        if (rd_dly == 0) begin
          mem_rvalid = 1;
          mem_rdata  = mem[rd_addr[11:2]];
          rd_pend    = 0;
        end else rd_dly--;
      end else if (mem_req && ($urandom % 4 != 0)) begin
        mem_gnt = 1;
        n_req++;
        if (!first_seen) begin first_rd = mem_addr; first_seen = 1; end
        if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
        else begin rd_pend = 1; rd_addr = mem_addr; rd_dly = $urandom % 3; end
      end
      #1;
      if (line_valid && line_ready) begin got_b.push_back(byte_data); got_l.push_back(byte_last); got_line++; end
      if (lb_valid && lb_ready)     begin got_b.push_back(byte_data); got_l.push_back(byte_last); got_lb++;   end
      if (pkt_sent_stb) n_sent++;
      if (underrun_stb) n_under++;
    end
  end

  function automatic logic [7:0] exp_byte(int k, int i);
    logic [31:0] w;
    w = mem[(32'h800 + k * 256) / 4 + i / 4];
    return w[8 * (i % 4) +: 8];
  endfunction

  task automatic clear_logs();
    got_b.delete(); got_l.delete();
    got_line = 0; got_lb = 0; n_sent = 0; n_under = 0; n_req = 0; first_seen = 0; first_rd = '0;
  endtask

  task automatic setup_chain(int n);
    for (int k = 0; k < n; k++) begin
      int base;
      int bufa;
      base = 32'h100 + k * 16;
      bufa = 32'h800 + k * 256;
      szo[k] = ($urandom & 32'h7FFF_F800) | 32'(lens[k]);
      mem[base / 4]     = bufa;
      mem[base / 4 + 1] = szo[k];
      mem[base / 4 + 2] = (base + 16) | ($urandom % 4);
      for (int w = 0; w < 64; w++) mem[bufa / 4 + w] = $urandom;
    end
    mem[(32'h100 + n * 16) / 4 + 1] = 32'h8000_0000 | ($urandom & 32'h7FF);
    @(negedge clk);
    desc_ptr_wr = 1; desc_ptr_wdata = 32'h100 | ($urandom % 4);
    @(negedge clk);
    desc_ptr_wr = 0;
  endtask

  task automatic run_walk(bit lb);
    loopback_sel = lb;
    clear_logs();
    @(negedge clk);
    dma_en_wr = 1; dma_en_wdata = 1;
    @(negedge clk);
    dma_en_wr = 0;
    for (int t = 0; t < 20000 && n_under == 0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_walk(int n, bit lb);
    int exp_n = 0;
    int bad = -1;
    int badl = -1;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < lens[k]; i++) begin
        if (exp_n < got_b.size()) begin
          if (got_b[exp_n] !== exp_byte(k, i) && bad < 0) bad = exp_n;
          if (got_l[exp_n] != (i == lens[k] - 1) && badl < 0) badl = exp_n;
        end
        exp_n++;
      end
    chk(got_b.size() == exp_n, "R4 R9 byte count", got_b.size(), exp_n);
    chk(bad < 0, "R4 R6 byte order (first bad index)", bad, -1);
    chk(badl < 0, "R4 last marker (first bad index)", badl, -1);
    chk(lb ? (got_line == 0) : (got_lb == 0), "R7 idle stream count", lb ? got_line : got_lb, 0);
    chk(n_sent == n, "R5 R9 packet-sent pulses", n_sent, n);
    chk(n_under == 1, "R3 underrun pulses", n_under, 1);
    chk(dma_en == 0, "R3 enable after underrun", dma_en, 0);
    chk(first_rd == 32'h104, "R2 R8 first read address", first_rd, 32'h104);
    for (int k = 0; k < n; k++)
      chk(mem[(32'h100 + k * 16) / 4 + 1] == (szo[k] | 32'h8000_0000), "R5 written-back size word",
          mem[(32'h100 + k * 16) / 4 + 1], szo[k] | 32'h8000_0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    mac_tx_en = 1; loopback_sel = 0; dma_en_wr = 0; dma_en_wdata = 0;
    desc_ptr_wr = 0; desc_ptr_wdata = '0; rdy_full = 0;
    for (int i = 0; i < MW; i++) mem[i] = '0;
    clear_logs();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(!mem_req && !line_valid && !lb_valid, "R11 quiet after reset", {mem_req, line_valid, lb_valid}, 0);
    chk(dma_en == 0 && !pkt_sent_stb && !underrun_stb, "R11 enable and strobes", {dma_en, pkt_sent_stb, underrun_stb}, 0);

    // R1: transmit enable low blocks the walk
    lens[0] = 4;
    setup_chain(1);
    mac_tx_en = 0;
    clear_logs();
    @(negedge clk); dma_en_wr = 1; dma_en_wdata = 1;
    @(negedge clk); dma_en_wr = 0;
    repeat (40) @(negedge clk);
    chk(n_req == 0, "R1 no request with transmit disabled", n_req, 0);
    chk(dma_en == 1, "R1 enable bit still set", dma_en, 1);
    @(negedge clk); dma_en_wr = 1; dma_en_wdata = 0;
    @(negedge clk); dma_en_wr = 0;
    mac_tx_en = 1;

    // directed: odd lengths and a zero-length descriptor (R9), line stream
    lens[0] = 5; lens[1] = 0; lens[2] = 8;
    setup_chain(3);
    run_walk(0);
    check_walk(3, 0);

    // R8: restart over consumed chain underruns at same head
    run_walk(0);
    chk(got_b.size() == 0, "R8 restart sends nothing", got_b.size(), 0);
    chk(n_sent == 0 && n_under == 1, "R8 restart underruns at once", n_sent, 0);
    chk(first_rd == 32'h104, "R8 restart reads head again", first_rd, 32'h104);

    // directed loopback, full-rate ready
    rdy_full = 1;
    lens[0] = 7; lens[1] = 1;
    setup_chain(2);
    run_walk(1);
    check_walk(2, 1);
    rdy_full = 0;

    // constrained random chains
    for (int r = 0; r < 14; r++) begin
      int n;
      bit lb;
      n = 1 + ($urandom % 4);
      lb = $urandom % 2;
      rdy_full = ($urandom % 4 == 0);
      for (int k = 0; k < n; k++) lens[k] = $urandom % 61;
      setup_chain(n);
      run_walk(lb);
      check_walk(n, lb);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule